// File: doc/BRIEF.md
# Indirect Address Pointer Unit

This block keeps a bank of eight 16-bit pointer registers for indirect data addressing, together with a small unsigned adder that moves them. A 3-bit selector names the pointer used by the current access. That pointer's value goes out as the data address. On the same clock edge the pointer can stay as it is, move by one, or move by the amount held in register 0. All pointer arithmetic wraps modulo 65536, so a pointer can reach any location in the 16-bit data space.

Register 0 has a second job as the compare operand. A compare operation tests the selected pointer against register 0 under one of four unsigned conditions and stores the outcome in a single test flag. A decoded micro-operation drives the block. Software, or the surrounding datapath, can load any register directly and read any register back.

Top module: `ptr_addr_unit`

## Requirements
- R1: While rst_n is low, all eight pointers, the selector (sel_q) and the test flag (flag_q) are zero.
- R2: addr_out always shows the pointer named by sel_q as it is before any update at the coming edge, so addressing is post-modify.
- R3: When acc_en is high, the selected pointer is updated at the clock edge according to step_mode: 0 leaves it unchanged, 1 adds one, 2 subtracts one, 3 adds register 0, 4 subtracts register 0, and 5 to 7 leave it unchanged. All results wrap modulo 65536.
- R4: When acc_en and sel_load are both high, sel_q takes sel_new at the edge. The access in that same cycle still uses the old selector.
- R5: When cmp_en is high, flag_q takes the unsigned result of comparing the selected pointer (value before update) with register 0. The cmp_cond codes are 0 equal, 1 less than, 2 greater than, 3 not equal. When cmp_en is low, flag_q holds its value.
- R6: When wr_en is high, register wr_idx takes wr_data at the edge. This write wins over an arithmetic update of the same register in that cycle. A write to a different register does not stop the update.
- R7: rd_data always shows the current contents of register rd_idx.
- R8: When acc_en is low, step_mode and sel_load have no effect, and with wr_en also low no register changes.
- R9: When register 0 is itself selected and step_mode is 3 or 4, the step amount is its value before the update. Adding therefore doubles it, and subtracting clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | An access happens this cycle |
| step_mode | input | 3 | Post-access update code |
| sel_load | input | 1 | Load a new selector with this access |
| sel_new | input | 3 | Selector value for the next access |
| cmp_en | input | 1 | Latch a compare result into the flag |
| cmp_cond | input | 2 | Compare condition code |
| wr_en | input | 1 | Direct register write |
| wr_idx | input | 3 | Register written |
| wr_data | input | 16 | Write value |
| rd_idx | input | 3 | Register read |
| rd_data | output | 16 | Read value |
| addr_out | output | 16 | Data address, from the selected pointer |
| sel_q | output | 3 | Current selector |
| flag_q | output | 1 | Test flag |

## Verification
The assertions assume that every control input is a known 0 or 1 at each rising edge once reset is released, and that all inputs change only between edges. They also assume that step codes 5 to 7 are legal inputs with the hold meaning. The stimulus drives every input on the falling edge from seeded $urandom values or from directed cases, and so never produces an unknown value. It covers the full step-code range and lets writes, accesses and compares land on the same register in the same cycle.

// File: rtl/ptr_au_pkg.sv
package ptr_au_pkg;
    localparam int unsigned AU_DW   = 16;
    localparam int unsigned AU_NREG = 8;

    typedef enum logic [2:0] {
        STEP_HOLD = 3'd0,
        STEP_INC  = 3'd1,
        STEP_DEC  = 3'd2,
        STEP_ADDX = 3'd3,
        STEP_SUBX = 3'd4
    } step_e;

    typedef enum logic [1:0] {
        COND_EQ = 2'd0,
        COND_LT = 2'd1,
        COND_GT = 2'd2,
        COND_NE = 2'd3
    } cond_e;
endpackage

// File: rtl/ptr_au_step.sv
module ptr_au_step
    import ptr_au_pkg::*;
#(
    parameter int unsigned DW = AU_DW
) (
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] idx,
    input  logic [2:0]    mode,
    output logic [DW-1:0] nxt
);
    localparam logic [DW-1:0] ONE = DW'(1);

    always_comb begin
        case (mode)
            STEP_INC:  nxt = cur + ONE;
            STEP_DEC:  nxt = cur - ONE;
            STEP_ADDX: nxt = cur + idx;
            STEP_SUBX: nxt = cur - idx;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/ptr_au_cmp.sv
module ptr_au_cmp
    import ptr_au_pkg::*;
#(
    parameter int unsigned DW = AU_DW
) (
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  logic [1:0]    cond,
    output logic          hit
);
    always_comb begin
        case (cond)
            COND_EQ: hit = (lhs == rhs);
            COND_LT: hit = (lhs <  rhs);
            COND_GT: hit = (lhs >  rhs);
            default: hit = (lhs != rhs);
        endcase
    end
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
    import ptr_au_pkg::*;
#(
    parameter int unsigned DW   = AU_DW,
    parameter int unsigned NREG = AU_NREG
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_en,
    input  logic [2:0]               step_mode,
    input  logic                     sel_load,
    input  logic [$clog2(NREG)-1:0]  sel_new,
    input  logic                     cmp_en,
    input  logic [1:0]               cmp_cond,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [$clog2(NREG)-1:0]  rd_idx,
    output logic [DW-1:0]            rd_data,
    output logic [DW-1:0]            addr_out,
    output logic [$clog2(NREG)-1:0]  sel_q,
    output logic                     flag_q
);
    localparam int unsigned SELW = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] ptr;
        logic [SELW-1:0]         sel;
        logic                    flag;
    } au_state_t;

    au_state_t st_d, st_q;

    logic [DW-1:0]           cur_ptr;
    logic [DW-1:0]           upd_val;
    logic                    cmp_hit;
    logic [NREG-1:0][DW-1:0] ptr_view;

    assign cur_ptr  = st_q.ptr[st_q.sel];
    assign addr_out = cur_ptr;
    assign rd_data  = st_q.ptr[rd_idx];
    assign sel_q    = st_q.sel;
    assign flag_q   = st_q.flag;
    assign ptr_view = st_q.ptr;

    ptr_au_step #(.DW(DW)) u_step (
        .cur  (cur_ptr),
        .idx  (st_q.ptr[0]),
        .mode (step_mode),
        .nxt  (upd_val)
    );

    ptr_au_cmp #(.DW(DW)) u_cmp (
        .lhs  (cur_ptr),
        .rhs  (st_q.ptr[0]),
        .cond (cmp_cond),
        .hit  (cmp_hit)
    );

    always_comb begin
        st_d = st_q;
        if (acc_en) begin
            st_d.ptr[st_q.sel] = upd_val;
            if (sel_load) begin
                st_d.sel = sel_new;
            end
        end
        if (cmp_en) begin
            st_d.flag = cmp_hit;
        end
        if (wr_en) begin
            st_d.ptr[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ptr_au_chk.sv
module ptr_au_chk #(
    parameter int unsigned DW   = 16,
    parameter int unsigned NREG = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     acc_en,
    input logic [2:0]               step_mode,
    input logic                     sel_load,
    input logic [$clog2(NREG)-1:0]  sel_new,
    input logic                     cmp_en,
    input logic                     wr_en,
    input logic [$clog2(NREG)-1:0]  wr_idx,
    input logic [DW-1:0]            wr_data,
    input logic [DW-1:0]            addr_out,
    input logic [$clog2(NREG)-1:0]  sel_q,
    input logic                     flag_q,
    input logic [NREG-1:0][DW-1:0]  ptr
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (sel_q == '0 && !flag_q && ptr == '0)); // R1

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && sel_load) |=> sel_q == $past(sel_new)); // R4

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && sel_load) |=> $stable(sel_q)); // R8

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> $stable(flag_q)); // R5

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ptr[$past(wr_idx)] == $past(wr_data)); // R6

    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && step_mode == 3'd1 && !(wr_en && wr_idx == sel_q))
        |=> ptr[$past(sel_q)] == DW'($past(addr_out) + DW'(1))); // R3

    AST_STEP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && step_mode == 3'd2 && !(wr_en && wr_idx == sel_q))
        |=> ptr[$past(sel_q)] == DW'($past(addr_out) - DW'(1))); // R3

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !wr_en) |=> $stable(ptr)); // R8
endmodule

bind ptr_addr_unit ptr_au_chk #(.DW(DW), .NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .step_mode (step_mode),
    .sel_load  (sel_load),
    .sel_new   (sel_new),
    .cmp_en    (cmp_en),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .addr_out  (addr_out),
    .sel_q     (sel_q),
    .flag_q    (flag_q),
    .ptr       (ptr_view)
);

// File: tb/ptr_addr_unit_test.sv
module ptr_addr_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 0, sel_load = 0, cmp_en = 0, wr_en = 0;
    logic [2:0]  step_mode = 0, sel_new = 0, wr_idx = 0, rd_idx = 0;
    logic [1:0]  cmp_cond = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_data, addr_out;
    logic [2:0]  sel_q;
    logic        flag_q;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_ptr [8];
    logic [2:0]  m_sel;
    logic        m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_addr_unit uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .step_mode(step_mode),
        .sel_load(sel_load), .sel_new(sel_new), .cmp_en(cmp_en),
        .cmp_cond(cmp_cond), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .addr_out(addr_out), .sel_q(sel_q), .flag_q(flag_q)
    );

    function automatic logic [15:0] exp_step(logic [15:0] cur, logic [15:0] amt, logic [2:0] m);
        case (m)
            3'd1: return cur + 16'd1;
            3'd2: return cur - 16'd1;
            3'd3: return cur + amt;
            3'd4: return cur - amt;
            default: return cur;
        endcase
    endfunction

    function automatic logic exp_cmp(logic [15:0] a, logic [15:0] b, logic [1:0] c);
        case (c)
            2'd0: return a == b;
            2'd1: return a < b;
            2'd2: return a > b;
            default: return a != b;
        endcase
    endfunction

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_ports();
        chk("R2 addr_out", addr_out, m_ptr[m_sel]);
        chk("R7 rd_data", rd_data, m_ptr[rd_idx]);
        chk("R4 sel_q", {13'd0, sel_q}, {13'd0, m_sel});
        chk("R5 flag_q", {15'd0, flag_q}, {15'd0, m_flag});
    endtask

    // drive at falling edge, check combinational outputs, then model the edge
    task automatic cyc(logic a, logic [2:0] sm, logic sl, logic [2:0] sn,
                       logic ce, logic [1:0] cc, logic we, logic [2:0] wi,
                       logic [15:0] wd, logic [2:0] ri);
        logic [15:0] upd;
        logic        hit;
        acc_en = a; step_mode = sm; sel_load = sl; sel_new = sn;
        cmp_en = ce; cmp_cond = cc; wr_en = we; wr_idx = wi; wr_data = wd; rd_idx = ri;
        #1;
        check_ports();
        upd = exp_step(m_ptr[m_sel], m_ptr[0], sm);
        hit = exp_cmp(m_ptr[m_sel], m_ptr[0], cc);
        @(posedge clk);
        if (a) begin
            m_ptr[m_sel] = upd;
            if (sl) m_sel = sn;
        end
        if (ce) m_flag = hit;
        if (we) m_ptr[wi] = wd;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) m_ptr[i] = 16'd0;
        m_sel = 3'd0;
        m_flag = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset state through the read port
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #1;
            chk("R1 reset reg", rd_data, 16'd0);
        end
        chk("R1 reset sel", {13'd0, sel_q}, 16'd0);
        chk("R1 reset flag", {15'd0, flag_q}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 wrap: AR1 = FFFF, +1 -> 0, -1 -> FFFF
        cyc(0,0,0,0, 0,0, 1,3'd1,16'hFFFF, 3'd1);
        cyc(1,0,1,3'd1, 0,0, 0,0,0, 3'd1);
        cyc(1,3'd1,0,0, 0,0, 0,0,0, 3'd1);
        chk("R3 wrap up", rd_data, 16'h0000);
        cyc(1,3'd2,0,0, 0,0, 0,0,0, 3'd1);
        chk("R3 wrap down", rd_data, 16'hFFFF);
        // R3 index steps with AR0 = 5
        cyc(0,0,0,0, 0,0, 1,3'd0,16'd5, 3'd1);
        cyc(1,3'd3,0,0, 0,0, 0,0,0, 3'd1);
        chk("R3 add AR0", rd_data, 16'h0004);
        cyc(1,3'd4,0,0, 0,0, 0,0,0, 3'd1);
        chk("R3 sub AR0", rd_data, 16'hFFFF);
        cyc(1,3'd6,0,0, 0,0, 0,0,0, 3'd1);
        chk("R3 code 6 holds", rd_data, 16'hFFFF);
        // R8: ignored when acc_en low
        cyc(0,3'd1,1,3'd4, 0,0, 0,0,0, 3'd1);
        chk("R8 no access", rd_data, 16'hFFFF);
        chk("R8 sel kept", {13'd0, sel_q}, 16'd1);
        // R6: write beats update on same register; other register update survives
        cyc(1,3'd1,0,0, 0,0, 1,3'd1,16'h1234, 3'd1);
        chk("R6 write wins", rd_data, 16'h1234);
        cyc(1,3'd1,0,0, 0,0, 1,3'd2,16'h0042, 3'd1);
        chk("R6 other update", rd_data, 16'h1235);
        // R5: compare AR1(1235) with AR0(5), each condition
        cyc(0,0,0,0, 1,2'd0, 0,0,0, 3'd0);
        chk("R5 eq", {15'd0, flag_q}, 16'd0);
        cyc(0,0,0,0, 1,2'd2, 0,0,0, 3'd0);
        chk("R5 gt", {15'd0, flag_q}, 16'd1);
        cyc(0,0,0,0, 1,2'd1, 0,0,0, 3'd0);
        chk("R5 lt", {15'd0, flag_q}, 16'd0);
        cyc(0,0,0,0, 1,2'd3, 0,0,0, 3'd0);
        chk("R5 ne", {15'd0, flag_q}, 16'd1);
        // R9: AR0 selected, add then subtract itself
        cyc(1,3'd0,1,3'd0, 0,0, 0,0,0, 3'd0);
        cyc(1,3'd3,0,0, 0,0, 0,0,0, 3'd0);
        chk("R9 double", rd_data, 16'd10);
        cyc(1,3'd4,0,0, 0,0, 0,0,0, 3'd0);
        chk("R9 clear", rd_data, 16'd0);

        // random mix
        for (int n = 0; n < 600; n++) begin
            cyc(1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom),
                1'($urandom), 2'($urandom), ($urandom % 4) == 0, 3'($urandom),
                (($urandom % 4) == 0) ? 16'($urandom % 3) : 16'($urandom), 3'($urandom));
        end
        #1;
        check_ports();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule